// File: doc/BRIEF.md
# In-Place Bit-Reversal Reorder Buffer

This block takes an unbroken stream of fixed-length frames, one sample per accepted clock, and hands each frame back in bit-reversed index order. It needs only one RAM of frame length. Each accepted sample first reads the word held at the current address and then overwrites it. The reading and writing run together, so no second bank or commutator chain is needed.

The address comes from a frame counter. Each bit of the counter passes through its own two-way selector. One input of the selector is the counter bit itself. The other is the mirrored bit from the far end of the counter. The selector setting changes every time a full frame has been accepted. When the setting is natural, a frame stored earlier at mirrored locations is read back in reversed order. When the setting is mirrored, a frame stored at natural locations is read back in reversed order.

After reset the first frame only fills the RAM. From the second frame on, every accepted sample gives exactly one output sample. A marker flags the first output sample of each frame. Typical use is in front of a pipelined transform stage that expects its input in bit-reversed order.

Top module: `inplace_reorder_buf`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `out_sof` are 0.
- R2: The first DEPTH accepted samples after reset produce no output: `out_valid` stays 0 in the cycle after each of them.
- R3: Once the RAM is primed, the k-th output sample of a frame equals the input sample of the previous frame whose index is k with its log2(DEPTH) address bits reversed (for DEPTH=8, output order 0,4,2,6,1,5,3,7).
- R4: When the RAM is primed, each accepted input (`in_valid`=1 at a rising edge) gives `out_valid`=1 after that same edge. An output frame therefore starts exactly DEPTH accepted samples after its input frame started.
- R5: `out_sof` is 1 together with the first output sample of each frame and 0 on the other DEPTH-1 samples.
- R6: A cycle with `in_valid`=0 gives `out_valid`=0 after the next edge. It does not advance the sample index or the address order, so the stream carries on at the same position.
- R7: The reordering stays correct over any number of back-to-back frames. This covers frames stored under natural addressing and frames stored under mirrored addressing.
- R8: DEPTH must be a power of two and at least 2. Any other value stops elaboration.
- R9: `in_data` is ignored while `in_valid`=0. Such a value never appears on `out_data` in a later frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is accepted at this edge |
| in_data | input | WIDTH | Input sample, natural order |
| out_valid | output | 1 | `out_data` holds a reordered sample |
| out_data | output | WIDTH | Output sample, bit-reversed order |
| out_sof | output | 1 | First output sample of a frame |

## Verification
The bench builds the block with DEPTH=8 and WIDTH=8. With these values every one of the eight addresses is visited within a few cycles, and both address orders alternate several times in a short run. The mirror pattern 0,4,2,6,1,5,3,7 is short enough to check by index. Eight-bit samples allow a distinct value for each sample of each frame, plus a marker value that is driven only while input is stalled. This makes any misplaced read, or any write during a stall, show up in the output.

// File: rtl/reorder_pkg.sv
package reorder_pkg;

   // address ordering currently applied by the address generator
   typedef enum logic {
      ORD_NATURAL  = 1'b0,
      ORD_REVERSED = 1'b1
   } order_e;

   function automatic order_e order_flip(input order_e o);
      return (o == ORD_NATURAL) ? ORD_REVERSED : ORD_NATURAL;
   endfunction

endpackage

// File: rtl/reorder_addr_gen.sv
module reorder_addr_gen
   import reorder_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          frame_head,
   output logic          primed
);

   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   logic [AW-1:0] idx_q;
   order_e        order_q;
   logic          primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         order_q  <= ORD_NATURAL;
         primed_q <= 1'b0;
      end else if (step) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST_IDX) begin
            order_q  <= order_flip(order_q);
            primed_q <= 1'b1;
         end
      end
   end

   // one two-way selector per address bit: own bit or mirrored bit
   for (genvar b = 0; b < AW; b++) begin : g_bit_sel
      assign addr[b] = (order_q == ORD_REVERSED) ? idx_q[AW-1-b] : idx_q[b];
   end

   assign frame_head = (idx_q == '0);
   assign primed     = primed_q;

endmodule

// File: rtl/reorder_ram.sv
module reorder_ram #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   // storage array: no reset, written on every enabled cycle
   always_ff @(posedge clk) begin
      if (en) mem[addr] <= wdata;
   end

   // registered read sees the old word: read-first on same address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (en) rdata <= mem[addr];
   end

endmodule

// File: rtl/inplace_reorder_buf.sv
module inplace_reorder_buf #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data,
   output logic             out_sof
);

   // R8: frame length must be a power of two, at least 2
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("inplace_reorder_buf: DEPTH must be a power of two >= 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("inplace_reorder_buf: WIDTH must be at least 1");
   end

   logic [AW-1:0] addr;
   logic          frame_head;
   logic          primed;
   logic          valid_q;
   logic          sof_q;

   reorder_addr_gen #(.DEPTH(DEPTH)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (in_valid),
      .addr       (addr),
      .frame_head (frame_head),
      .primed     (primed)
   );

   reorder_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .addr  (addr),
      .wdata (in_data),
      .rdata (out_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         sof_q   <= 1'b0;
      end else begin
         valid_q <= in_valid & primed;
         sof_q   <= in_valid & primed & frame_head;
      end
   end

   assign out_valid = valid_q;
   assign out_sof   = sof_q;

endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic out_valid,
   input logic out_sof
);

   logic [AW:0]   acc_cnt;
   logic [AW-1:0] out_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_cnt <= '0;
         out_pos <= '0;
      end else begin
         if (in_valid && acc_cnt < (AW+1)'(DEPTH)) acc_cnt <= acc_cnt + 1'b1;
         if (out_valid) out_pos <= out_pos + 1'b1;
      end
   end

   a_r2_no_output_while_priming: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc_cnt < (AW+1)'(DEPTH)) |=> !out_valid);

   a_r4_output_after_prime: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc_cnt == (AW+1)'(DEPTH)) |=> out_valid);

   a_r6_stall_gives_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r5_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   a_r5_sof_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_sof == (out_pos == '0)));

endmodule

bind inplace_reorder_buf reorder_buf_chk #(.DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_sof   (out_sof)
);

// File: tb/inplace_reorder_buf_bench.sv
`timescale 1ns/1ps
module inplace_reorder_buf_bench;

   localparam int WIDTH = 8;
   localparam int DEPTH = 8;
   localparam int AW    = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [WIDTH-1:0] in_data = '0;
   logic             out_valid;
   logic [WIDTH-1:0] out_data;
   logic             out_sof;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model state
   logic [WIDTH-1:0] prev_f [DEPTH];
   logic [WIDTH-1:0] cur_f  [DEPTH];
   int               idx = 0;
   bit               primed = 0;

   always #4 clk = ~clk;

   inplace_reorder_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_inplace_reorder_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_sof   (out_sof)
   );

   function automatic int mirror(input int k);
      int r = 0;
      for (int b = 0; b < AW; b++) if (k[b]) r |= 1 << (AW - 1 - b);
      return r;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive, let the edge pass, compare with model
   task automatic step(input logic v, input logic [WIDTH-1:0] d, input string tag);
      logic exp_v, exp_s;
      logic [WIDTH-1:0] exp_d;
      in_valid = v;
      in_data  = d;
      exp_v = 1'b0; exp_s = 1'b0; exp_d = '0;
      if (v) begin
         exp_v = primed;
         exp_s = primed && (idx == 0);
         exp_d = prev_f[mirror(idx)];
         cur_f[idx] = d;
         idx++;
         if (idx == DEPTH) begin
            prev_f  = cur_f;
            idx     = 0;
            primed  = 1;
         end
      end
      @(posedge clk);
      #2;
      if (!v)            check("R6 valid", int'(out_valid), int'(exp_v));
      else if (!primed || !exp_v) check("R2 valid", int'(out_valid), int'(exp_v));
      else               check("R4 valid", int'(out_valid), int'(exp_v));
      if (exp_v) begin
         check(tag, int'(out_data), int'(exp_d));
         check("R5 sof", int'(out_sof), int'(exp_s));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      check("R1 valid in reset", int'(out_valid), 0);
      check("R1 sof in reset", int'(out_sof), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      check("R1 valid after reset", int'(out_valid), 0);
      check("R1 sof after reset", int'(out_sof), 0);
   endtask

   task automatic t_priming();
      for (int k = 0; k < DEPTH; k++) step(1'b1, 8'h10 + 8'(k), "R2 data");
   endtask

   task automatic t_stream();
      for (int k = 0; k < DEPTH; k++) step(1'b1, 8'h20 + 8'(k), "R3 data");
      for (int f = 0; f < 3; f++)
         for (int k = 0; k < DEPTH; k++) step(1'b1, 8'h40 + 8'(f * 16 + k), "R7 data");
   endtask

   task automatic t_stalls();
      for (int k = 0; k < DEPTH; k++) begin
         step(1'b0, 8'hEE, "R6 stall");
         step(1'b1, 8'h80 + 8'(k), "R6 data");
         if (k % 3 == 0) step(1'b0, 8'hEE, "R6 stall");
      end
      for (int k = 0; k < DEPTH; k++) step(1'b1, 8'hA0 + 8'(k), "R9 data");
      for (int k = 0; k < DEPTH; k++) step(1'b1, 8'hC0 + 8'(k), "R7 data");
   endtask

   initial begin
      for (int k = 0; k < DEPTH; k++) begin
         prev_f[k] = '0;
         cur_f[k]  = '0;
      end
      t_reset();
      t_priming();
      t_stream();
      t_stalls();
      step(1'b0, 8'hEE, "R6 stall");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      done = 1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule